// File: doc/BRIEF.md
# Power Mode and Reset Status Controller

This block decides which of four operating modes a small controller is in and, from that mode, drives three gating enables: one for the CPU, one for the fast system clock and one for the slow timekeeping clock. In run mode all three are on. In slow-run mode the fast clock stops and the CPU runs from the slow clock. In idle mode only the slow clock keeps running. In sleep mode all three are off. Software asks for a mode with a two-bit code or with a sleep instruction strobe. Wake-up events, a watchdog time-out or an external reset pulse bring the block back to run mode.

The block also keeps two sticky status bits that software reads after start-up to learn why it is running. The time-out bit T and the power-down bit P are updated by the sleep and watchdog-clear instruction strobes, the watchdog time-out and the external reset, as the requirements below describe. A request is first stored as a pending target. The committed mode, and with it the enables, follows on a slow-clock tick, except when the block leaves sleep. With the slow clock stopped, that exit has to happen on the next system clock.

All pins are plain one-cycle strobes or levels in the `clk` domain. The block has no data stream, so no valid/ready handshake or back-pressure applies. `slow_tick` is a one-cycle pulse that marks each slow-clock edge. `rst_n` is the asynchronous power-on reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the mode is run (code 00), T=1, P=1, and all three enables are 1.
- R2: The enables follow the committed mode: run 00 gives cpu=1 fast=1 slow=1; slow-run 01 gives cpu=1 fast=0 slow=1; idle 10 gives cpu=0 fast=0 slow=1; sleep 11 gives cpu=0 fast=0 slow=0.
- R3: `req_vld` with `req_mode` (00 run, 01 slow-run, 10 idle, 11 sleep) sets the pending target at the next clock. A `slow_tick` in a later cycle commits it. A tick in the same cycle as the request does not commit that request.
- R4: `sleep_cmd` makes sleep (11) the pending target and, at the next clock, sets T=1 and P=0.
- R5: `wdt_clr` sets T=1 and P=1 at the next clock.
- R6: `wdt_tmo` clears T at the next clock and makes run the pending target. P becomes 0 if the mode is sleep and 1 otherwise.
- R7: `ext_rst` makes run the pending target. In sleep it sets T=1 and P=0. In any other mode it leaves T and P unchanged.
- R8: `wake_evt` makes run the pending target when the mode is idle or sleep. In run or slow-run it has no effect on the mode.
- R9: A transition out of sleep is committed on the clock after the pending target changes, with no `slow_tick` needed. From any other mode the committed mode holds until a `slow_tick`.
- R10: When strobes coincide, status priority is `ext_rst`, then `wdt_tmo`, then `sleep_cmd`, then `wdt_clr`. For the pending target, a return to run beats `sleep_cmd`, which beats `req_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| slow_tick | input | 1 | One-cycle pulse per slow-clock edge |
| ext_rst | input | 1 | External reset pin pulse |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| sleep_cmd | input | 1 | Sleep instruction strobe |
| wdt_clr | input | 1 | Watchdog-clear instruction strobe |
| wake_evt | input | 1 | Wake-up event pulse |
| req_vld | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| mode_o | output | 2 | Committed mode code |
| cpu_en | output | 1 | CPU enable |
| fast_clk_en | output | 1 | Fast clock enable |
| slow_clk_en | output | 1 | Slow clock enable |
| stat_t | output | 1 | Time-out status bit |
| stat_p | output | 1 | Power-down status bit |

## Verification
The hardest cases to reach are the status outcomes that depend on the block being asleep at the moment a watchdog time-out or external reset arrives. Sleep is only entered through a sleep strobe or request followed by a separate slow tick, and the block leaves sleep one clock after the waking event. The stimulus table therefore walks explicit chains: request, tick, event in sleep, then an idle cycle. It samples T, P and the mode in each cycle, so both the sleep-specific status and the tick-free exit are seen. Coincident strobes are driven in single table rows to exercise the priority order.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_RUN   = 2'b00,
    PM_SLOW  = 2'b01,
    PM_IDLE  = 2'b10,
    PM_SLEEP = 2'b11
  } pm_mode_e;

  typedef struct packed {
    logic cpu;
    logic fast;
    logic slow;
  } pm_gate_t;
endpackage

// File: rtl/pmc_status.sv
module pmc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  input  logic wdt_tmo,
  input  logic sleep_cmd,
  input  logic wdt_clr,
  input  logic asleep,
  output logic stat_t,
  output logic stat_p
);
  logic t_q, p_q;

  // priority: external reset, time-out, sleep, watchdog clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= 1'b1;
      p_q <= 1'b1;
    end else if (ext_rst) begin
      if (asleep) begin
        t_q <= 1'b1;
        p_q <= 1'b0;
      end
    end else if (wdt_tmo) begin
      t_q <= 1'b0;
      p_q <= !asleep;
    end else if (sleep_cmd) begin
      t_q <= 1'b1;
      p_q <= 1'b0;
    end else if (wdt_clr) begin
      t_q <= 1'b1;
      p_q <= 1'b1;
    end
  end

  assign stat_t = t_q;
  assign stat_p = p_q;

  p_sleep_instr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_cmd && !ext_rst && !wdt_tmo |=> t_q && !p_q);
  p_wdt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr && !sleep_cmd && !ext_rst && !wdt_tmo |=> t_q && p_q);
  p_tmo_clears_t_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tmo && !ext_rst |=> !t_q);
  p_ext_awake_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst && !asleep |=> $stable(t_q) && $stable(p_q));
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              ext_rst,
  input  logic              wdt_tmo,
  input  logic              sleep_cmd,
  input  logic              wake_evt,
  input  logic              req_vld,
  input  logic [MODE_W-1:0] req_mode,
  output pm_mode_e          mode_o,
  output logic              asleep
);
  pm_mode_e pend_q, mode_q;
  logic     dormant, to_run;

  assign dormant = (mode_q == PM_SLEEP) || (mode_q == PM_IDLE);
  assign to_run  = ext_rst || wdt_tmo || (wake_evt && dormant);

  // pending target: return-to-run beats sleep strobe beats request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= PM_RUN;
    else if (to_run)    pend_q <= PM_RUN;
    else if (sleep_cmd) pend_q <= PM_SLEEP;
    else if (req_vld)   pend_q <= pm_mode_e'(req_mode);
  end

  // commit on slow tick; leaving sleep needs no tick (slow clock is stopped)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mode_q <= PM_RUN;
    else if (slow_tick || mode_q == PM_SLEEP) mode_q <= pend_q;
  end

  assign mode_o = mode_q;
  assign asleep = (mode_q == PM_SLEEP);

  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick && mode_q != PM_SLEEP |=> $stable(mode_q));
  p_sleep_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == PM_SLEEP |=> mode_q == $past(pend_q));
  p_wake_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt && mode_q == PM_IDLE |=> pend_q == PM_RUN);
endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
(
  input  pm_mode_e mode_i,
  output pm_gate_t gate_o
);
  always_comb begin
    unique case (mode_i)
      PM_RUN:   gate_o = '{cpu: 1'b1, fast: 1'b1, slow: 1'b1};
      PM_SLOW:  gate_o = '{cpu: 1'b1, fast: 1'b0, slow: 1'b1};
      PM_IDLE:  gate_o = '{cpu: 1'b0, fast: 1'b0, slow: 1'b1};
      default:  gate_o = '{cpu: 1'b0, fast: 1'b0, slow: 1'b0};
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       ext_rst,
  input  logic       wdt_tmo,
  input  logic       sleep_cmd,
  input  logic       wdt_clr,
  input  logic       wake_evt,
  input  logic       req_vld,
  input  logic [1:0] req_mode,
  output logic [1:0] mode_o,
  output logic       cpu_en,
  output logic       fast_clk_en,
  output logic       slow_clk_en,
  output logic       stat_t,
  output logic       stat_p
);
  pm_mode_e mode_w;
  pm_gate_t gate_w;
  logic     asleep_w;

  pmc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .ext_rst   (ext_rst),
    .wdt_tmo   (wdt_tmo),
    .sleep_cmd (sleep_cmd),
    .wake_evt  (wake_evt),
    .req_vld   (req_vld),
    .req_mode  (req_mode),
    .mode_o    (mode_w),
    .asleep    (asleep_w)
  );

  pmc_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_rst   (ext_rst),
    .wdt_tmo   (wdt_tmo),
    .sleep_cmd (sleep_cmd),
    .wdt_clr   (wdt_clr),
    .asleep    (asleep_w),
    .stat_t    (stat_t),
    .stat_p    (stat_p)
  );

  pmc_gate u_gate (
    .mode_i (mode_w),
    .gate_o (gate_w)
  );

  assign mode_o      = mode_w;
  assign cpu_en      = gate_w.cpu;
  assign fast_clk_en = gate_w.fast;
  assign slow_clk_en = gate_w.slow;

  p_cpu_needs_slow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> slow_clk_en);
  p_fast_needs_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk_en |-> cpu_en);
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 0, ext_rst = 0, wdt_tmo = 0, sleep_cmd = 0, wdt_clr = 0;
  logic wake_evt = 0, req_vld = 0;
  logic [1:0] req_mode = 2'b00;
  logic [1:0] mode_o;
  logic cpu_en, fast_clk_en, slow_clk_en, stat_t, stat_p;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ext_rst(ext_rst),
    .wdt_tmo(wdt_tmo), .sleep_cmd(sleep_cmd), .wdt_clr(wdt_clr),
    .wake_evt(wake_evt), .req_vld(req_vld), .req_mode(req_mode),
    .mode_o(mode_o), .cpu_en(cpu_en), .fast_clk_en(fast_clk_en),
    .slow_clk_en(slow_clk_en), .stat_t(stat_t), .stat_p(stat_p)
  );

  // {req id, er wt sl wc rv rq[1:0] wk tk, exp mode[1:0] T P}
  localparam int NV = 40;
  localparam logic [16:0] VEC [NV] = '{
    {4'd3,  9'b000010100, 4'b0011}, // R3 request slow-run, no tick
    {4'd3,  9'b000000001, 4'b0111}, // R3 tick commits
    {4'd8,  9'b000000010, 4'b0111}, // R8 wake ignored in slow-run
    {4'd8,  9'b000000001, 4'b0111}, // R8 tick, still slow-run
    {4'd3,  9'b000011001, 4'b0111}, // R3 request idle with same-cycle tick
    {4'd3,  9'b000000001, 4'b1011}, // R3 next tick commits idle
    {4'd8,  9'b000000010, 4'b1011}, // R8 wake in idle pends run
    {4'd9,  9'b000000001, 4'b0011}, // R9 idle exit waits for tick
    {4'd4,  9'b001000000, 4'b0010}, // R4 sleep strobe: T=1 P=0
    {4'd4,  9'b000000001, 4'b1110}, // R4 tick enters sleep
    {4'd9,  9'b000000000, 4'b1110}, // R9 sleep holds
    {4'd8,  9'b000000010, 4'b1110}, // R8 wake in sleep
    {4'd9,  9'b000000000, 4'b0010}, // R9 exit without tick
    {4'd5,  9'b000100000, 4'b0011}, // R5 watchdog clear
    {4'd6,  9'b010000000, 4'b0001}, // R6 time-out awake: T=0 P=1
    {4'd5,  9'b000100000, 4'b0011}, // R5 watchdog clear again
    {4'd10, 9'b001010100, 4'b0010}, // R10 sleep strobe beats request
    {4'd10, 9'b000000001, 4'b1110}, // R10 tick enters sleep
    {4'd6,  9'b010000000, 4'b1100}, // R6 time-out in sleep: T=0 P=0
    {4'd9,  9'b000000000, 4'b0000}, // R9 exit after time-out
    {4'd3,  9'b000010100, 4'b0000}, // R3 request slow-run
    {4'd3,  9'b000000001, 4'b0100}, // R3 tick
    {4'd7,  9'b100000000, 4'b0100}, // R7 ext reset awake: T,P kept
    {4'd7,  9'b000000001, 4'b0000}, // R7 tick returns to run
    {4'd4,  9'b001000000, 4'b0010}, // R4 sleep strobe
    {4'd4,  9'b000000001, 4'b1110}, // R4 enter sleep
    {4'd7,  9'b100000000, 4'b1110}, // R7 ext reset in sleep: T=1 P=0
    {4'd9,  9'b000000000, 4'b0010}, // R9 exit without tick
    {4'd10, 9'b011100000, 4'b0001}, // R10 time-out beats sleep and clear
    {4'd10, 9'b000000001, 4'b0001}, // R10 no sleep entered
    {4'd5,  9'b000100000, 4'b0011}, // R5 watchdog clear
    {4'd10, 9'b110000000, 4'b0011}, // R10 ext reset beats time-out
    {4'd3,  9'b000011000, 4'b0011}, // R3 request idle
    {4'd3,  9'b000000001, 4'b1011}, // R3 tick commits idle
    {4'd6,  9'b010000000, 4'b1001}, // R6 time-out in idle: T=0 P=1
    {4'd6,  9'b000000001, 4'b0001}, // R6 tick returns to run
    {4'd3,  9'b000011100, 4'b0001}, // R3 request sleep by code 11
    {4'd3,  9'b000000001, 4'b1101}, // R3 tick enters sleep, T,P kept
    {4'd8,  9'b000000010, 4'b1101}, // R8 wake in sleep
    {4'd9,  9'b000000000, 4'b0001}  // R9 exit without tick
  };

  // R2 enable table, kept in the bench
  function automatic logic [2:0] exp_gate(input logic [1:0] m);
    case (m)
      2'b00:   return 3'b111;
      2'b01:   return 3'b101;
      2'b10:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] em, input logic et, input logic ep);
    logic [2:0] eg, ag;
    eg = exp_gate(em);
    ag = {cpu_en, fast_clk_en, slow_clk_en};
    n_run++;
    if (mode_o !== em || stat_t !== et || stat_p !== ep || ag !== eg) begin
      n_fail++;
      $display("FAIL %s: got mode=%b T=%b P=%b en=%b, expected mode=%b T=%b P=%b en=%b",
               tag, mode_o, stat_t, stat_p, ag, em, et, ep, eg);
    end
  endtask

  task automatic drive(input logic [8:0] c);
    @(negedge clk);
    {ext_rst, wdt_tmo, sleep_cmd, wdt_clr, req_vld, req_mode, wake_evt, slow_tick} = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", 2'b00, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", 2'b00, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12:4]);
      check($sformatf("R%0d vec %0d", VEC[i][16:13], i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end
    drive(9'b0);
    check("R9 quiet run", 2'b00, 1'b0, 1'b1);

    // R1 mid-run reset from slow-run
    drive(9'b000010100);
    drive(9'b000000001);
    check("R3 slow-run before reset", 2'b01, 1'b0, 1'b1);
    @(negedge clk);
    {ext_rst, wdt_tmo, sleep_cmd, wdt_clr, req_vld, req_mode, wake_evt, slow_tick} = '0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 2'b00, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    drive(9'b000000001);
    check("R1 reset clears pending", 2'b00, 1'b1, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule